// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block produces every digital clock and gate needed to read out a two-phase linear CCD with an electronic shutter. Each line runs through a fixed sequence of states. XFER raises the transfer gate and holds the first horizontal clock high. READ clocks out the full register of lead dummy, effective and tail dummy pixels. DUMMY clocks out a programmable number of extra pixels that stretch the line. INTEG opens the shutter (all-reset gate released) for the exposure, which ends when the next XFER starts. The state machine also has an IDLE state, which it holds during reset.

The pixel period, extra dummy count, exposure length, transfer time and the low-level (MPP) resistive-gate mode are runtime inputs counted in system clocks. They are captured once, on entry to XFER, and the captured values govern that whole line. The block also drives a pixel-valid flag for the effective pixels, an ADC sample strobe at a fixed phase of each pixel, and a one-cycle line-start pulse.

State transitions:
- IDLE→XFER: after reset is released.
- XFER→READ: after `TG_CYC` cycles.
- READ→DUMMY: at the end of the last register pixel when the extra count is nonzero; READ→INTEG when the count is zero.
- DUMMY→INTEG: after the last extra pixel.
- INTEG→XFER: after the exposure length.
- Any state→IDLE: on reset.

Top module: `lccd_timing_gen`

## Requirements
- R1: A line is one XFER, then READ, then DUMMY (skipped when the extra count is 0), then INTEG, and then the next line begins. The line lasts TG_CYC + (N_LEAD+N_EFF+N_TAIL+extra)·P + I system clocks, where P is the effective pixel period and I is the effective exposure. `line_start` is high for exactly the first cycle of XFER and at no other time.
- R2: `xfer_gate` is high for exactly TG_CYC cycles per line. `hclk1` is high during every one of those cycles, and `hclk2` and `sum_gate` are low.
- R3: In READ and DUMMY each pixel lasts P clocks, where P is `cfg_pix_period` raised to MIN_PIX if smaller. Within a pixel, `hclk1` is high for the first floor(P/2) clocks and `hclk2` for the remaining P−floor(P/2) clocks. The two are never high together, and `sum_gate` always equals `hclk2`.
- R4: `rst_gate` is a single-clock pulse on the first clock of each pixel. `adc_strobe` is a single-clock pulse ADC_OFF clocks after it, in every pixel.
- R5: `pix_valid` is high only during the N_EFF effective pixels of READ. These follow exactly N_LEAD reset-gate pulses of the line, so the flag is high for N_EFF·P cycles per line.
- R6: `sh_close` is low only in INTEG. INTEG lasts `cfg_integ_cyc` cycles, raised to MIN_INTEG if smaller.
- R7: With MPP enabled, `rgate_low` is high for the first I−X cycles of INTEG and is then released for the last X cycles before XFER, where X is `cfg_xfer_cyc`. It is never high when X ≥ I, never high when MPP is disabled, and never high outside INTEG.
- R8: The configuration inputs are captured only on entry to XFER. A change made during a line has no effect on that line and takes effect on the next one.
- R9: While `rst` is high, `sh_close` is high and every other output is low. The first `line_start` appears one clock after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pix_period | input | PIX_W | Pixel period in clocks (minimum MIN_PIX) |
| cfg_dummy_cnt | input | N_W | Extra dummy pixels per line |
| cfg_integ_cyc | input | INT_W | Exposure length in clocks (minimum MIN_INTEG) |
| cfg_xfer_cyc | input | INT_W | Resistive-gate recovery time before XFER, in MPP mode |
| cfg_mpp_en | input | 1 | Enables the low resistive-gate level during exposure |
| sh_close | output | 1 | All-reset gate; high means the shutter is closed |
| xfer_gate | output | 1 | Transfer gate |
| hclk1 | output | 1 | Horizontal clock, first phase |
| hclk2 | output | 1 | Horizontal clock, second phase |
| sum_gate | output | 1 | Summing gate |
| rst_gate | output | 1 | Output-node reset gate pulse |
| rgate_low | output | 1 | Selects the low level for both resistive-gate lines |
| pix_valid | output | 1 | High during effective pixels |
| adc_strobe | output | 1 | Converter sample strobe |
| line_start | output | 1 | One-cycle pulse at the start of each XFER |

## Verification
The assertions check, on every cycle, the relations that must hold at any moment:
- `hclk1` is high throughout the transfer gate.
- The two horizontal clocks never overlap.
- The reset-gate pulse is a single cycle.
- The valid flag appears only while the shutter is closed.
- The low resistive-gate level and the transfer gate appear only in their proper shutter state.
- The captured configuration stays stable through a readout.

Only the bench's scenarios can show the quantities that accumulate over a line: the line length, the pixel count including the clamped period, the clamped exposure, the MPP low window, the position of the first valid pixel, and the deferral of a mid-line configuration change to the next line.

// File: rtl/lccd_pkg.sv
package lccd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_XFER  = 3'd1,
        ST_READ  = 3'd2,
        ST_DUMMY = 3'd3,
        ST_INTEG = 3'd4
    } lccd_state_e;
endpackage

// File: rtl/lccd_line_fsm.sv
module lccd_line_fsm
    import lccd_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int N_W       = 16,
    parameter int INT_W     = 20,
    parameter int N_TOT     = 2128,
    parameter int TG_CYC    = 300,
    parameter int MIN_INTEG = 200,
    parameter int MIN_PIX   = 4,
    parameter int IDX_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  cfg_pix_period,
    input  logic [N_W-1:0]    cfg_dummy_cnt,
    input  logic [INT_W-1:0]  cfg_integ_cyc,
    input  logic [INT_W-1:0]  cfg_xfer_cyc,
    input  logic              cfg_mpp_en,
    output lccd_state_e       state,
    output logic [INT_W-1:0]  cnt,
    output logic [PIX_W-1:0]  ph,
    output logic [IDX_W-1:0]  pix,
    output logic [PIX_W-1:0]  lat_half,
    output logic              lat_mpp,
    output logic [INT_W-1:0]  lat_rglow
);
    localparam logic [INT_W-1:0] TG_LAST  = INT_W'(TG_CYC - 1);
    localparam logic [IDX_W-1:0] PIX_LAST = IDX_W'(N_TOT - 1);
    localparam logic [PIX_W-1:0] PIX_MIN  = PIX_W'(MIN_PIX);
    localparam logic [INT_W-1:0] INT_MIN  = INT_W'(MIN_INTEG);

    lccd_state_e      nxt;
    logic [PIX_W-1:0] lat_pix;
    logic [IDX_W-1:0] lat_dummy;
    logic [INT_W-1:0] lat_integ;
    logic             pix_end;
    logic [PIX_W-1:0] cap_pix;
    logic [INT_W-1:0] cap_integ;

    assign pix_end   = (ph == lat_pix - PIX_W'(1));
    assign cap_pix   = (cfg_pix_period < PIX_MIN) ? PIX_MIN : cfg_pix_period;
    assign cap_integ = (cfg_integ_cyc < INT_MIN) ? INT_MIN : cfg_integ_cyc;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = ST_XFER;
            ST_XFER:  if (cnt == TG_LAST) nxt = ST_READ;
            ST_READ:  if (pix_end && pix == PIX_LAST)
                          nxt = (lat_dummy == '0) ? ST_INTEG : ST_DUMMY;
            ST_DUMMY: if (pix_end && pix == lat_dummy - IDX_W'(1)) nxt = ST_INTEG;
            ST_INTEG: if (cnt == lat_integ - INT_W'(1)) nxt = ST_XFER;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            ph        <= '0;
            pix       <= '0;
            lat_pix   <= PIX_MIN;
            lat_half  <= PIX_MIN >> 1;
            lat_dummy <= '0;
            lat_integ <= INT_MIN;
            lat_mpp   <= 1'b0;
            lat_rglow <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                cnt <= '0;
                ph  <= '0;
                pix <= '0;
            end else if (state == ST_READ || state == ST_DUMMY) begin
                if (pix_end) begin
                    ph  <= '0;
                    pix <= pix + IDX_W'(1);
                end else begin
                    ph <= ph + PIX_W'(1);
                end
            end else begin
                cnt <= cnt + INT_W'(1);
            end
            if (nxt == ST_XFER && state != ST_XFER) begin
                lat_pix   <= cap_pix;
                lat_half  <= cap_pix >> 1;
                lat_dummy <= IDX_W'(cfg_dummy_cnt);
                lat_integ <= cap_integ;
                lat_mpp   <= cfg_mpp_en;
                lat_rglow <= (cap_integ > cfg_xfer_cyc) ? cap_integ - cfg_xfer_cyc : '0;
            end
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ && $past(state) == ST_READ) |-> ($stable(lat_pix) && $stable(lat_rglow))) // R8
        else $error("captured configuration changed during readout");

    AST_RST_IDLE: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE)) // R9
        else $error("state not idle after reset");
endmodule

// File: rtl/lccd_out_decode.sv
module lccd_out_decode
    import lccd_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int INT_W   = 20,
    parameter int IDX_W   = 16,
    parameter int N_LEAD  = 70,
    parameter int N_EFF   = 2048,
    parameter int ADC_OFF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  lccd_state_e       state,
    input  logic [INT_W-1:0]  cnt,
    input  logic [PIX_W-1:0]  ph,
    input  logic [IDX_W-1:0]  pix,
    input  logic [PIX_W-1:0]  lat_half,
    input  logic              lat_mpp,
    input  logic [INT_W-1:0]  lat_rglow,
    output logic              sh_close,
    output logic              xfer_gate,
    output logic              hclk1,
    output logic              hclk2,
    output logic              sum_gate,
    output logic              rst_gate,
    output logic              rgate_low,
    output logic              pix_valid,
    output logic              adc_strobe,
    output logic              line_start
);
    localparam logic [IDX_W-1:0] EFF_LO = IDX_W'(N_LEAD);
    localparam logic [IDX_W-1:0] EFF_HI = IDX_W'(N_LEAD + N_EFF);
    localparam logic [PIX_W-1:0] ADC_PH = PIX_W'(ADC_OFF);

    always_comb begin
        sh_close   = 1'b1;
        xfer_gate  = 1'b0;
        hclk1      = 1'b0;
        hclk2      = 1'b0;
        sum_gate   = 1'b0;
        rst_gate   = 1'b0;
        rgate_low  = 1'b0;
        pix_valid  = 1'b0;
        adc_strobe = 1'b0;
        line_start = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_XFER: begin
                xfer_gate  = 1'b1;
                hclk1      = 1'b1;
                line_start = (cnt == '0);
            end
            ST_READ, ST_DUMMY: begin
                hclk1      = (ph < lat_half);
                hclk2      = (ph >= lat_half);
                sum_gate   = (ph >= lat_half);
                rst_gate   = (ph == '0);
                adc_strobe = (ph == ADC_PH);
                pix_valid  = (state == ST_READ) && (pix >= EFF_LO) && (pix < EFF_HI);
            end
            ST_INTEG: begin
                sh_close  = 1'b0;
                hclk1     = 1'b1;
                rgate_low = lat_mpp && (cnt < lat_rglow);
            end
            default: ;
        endcase
    end

    AST_LS_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (xfer_gate && sh_close)) // R1
        else $error("line_start outside transfer");
    AST_TG_HCLK1: assert property (@(posedge clk) disable iff (rst)
        xfer_gate |-> (hclk1 && !hclk2 && !sum_gate)) // R2
        else $error("hclk1 not held during transfer gate");
    AST_HCLK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(hclk1 && hclk2)) // R3
        else $error("horizontal clocks overlap");
    AST_RG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rst_gate |=> !rst_gate) // R4
        else $error("reset gate wider than one cycle");
    AST_VALID_CLOSED: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (sh_close && !xfer_gate)) // R5
        else $error("pix_valid while shutter open or transferring");
    AST_OPEN_NO_TG: assert property (@(posedge clk) disable iff (rst)
        !sh_close |-> !xfer_gate) // R6
        else $error("transfer gate with shutter open");
    AST_RGLOW_OPEN: assert property (@(posedge clk) disable iff (rst)
        rgate_low |-> !sh_close) // R7
        else $error("resistive gate low outside exposure");
endmodule

// File: rtl/lccd_timing_gen.sv
module lccd_timing_gen
    import lccd_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int N_W       = 16,
    parameter int INT_W     = 20,
    parameter int N_LEAD    = 70,
    parameter int N_EFF     = 2048,
    parameter int N_TAIL    = 10,
    parameter int TG_CYC    = 300,
    parameter int MIN_INTEG = 200,
    parameter int MIN_PIX   = 4,
    parameter int ADC_OFF   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] cfg_pix_period,
    input  logic [N_W-1:0]   cfg_dummy_cnt,
    input  logic [INT_W-1:0] cfg_integ_cyc,
    input  logic [INT_W-1:0] cfg_xfer_cyc,
    input  logic             cfg_mpp_en,
    output logic             sh_close,
    output logic             xfer_gate,
    output logic             hclk1,
    output logic             hclk2,
    output logic             sum_gate,
    output logic             rst_gate,
    output logic             rgate_low,
    output logic             pix_valid,
    output logic             adc_strobe,
    output logic             line_start
);
    localparam int N_TOT = N_LEAD + N_EFF + N_TAIL;
    localparam int IDX_W = ($clog2(N_TOT + 1) > N_W) ? $clog2(N_TOT + 1) : N_W;

    initial begin
        assert (ADC_OFF > 0 && ADC_OFF < MIN_PIX)
            else $error("ADC_OFF must lie inside the shortest pixel");
    end

    lccd_state_e      state;
    logic [INT_W-1:0] cnt;
    logic [PIX_W-1:0] ph;
    logic [IDX_W-1:0] pix;
    logic [PIX_W-1:0] lat_half;
    logic             lat_mpp;
    logic [INT_W-1:0] lat_rglow;

    lccd_line_fsm #(
        .PIX_W(PIX_W), .N_W(N_W), .INT_W(INT_W), .N_TOT(N_TOT),
        .TG_CYC(TG_CYC), .MIN_INTEG(MIN_INTEG), .MIN_PIX(MIN_PIX), .IDX_W(IDX_W)
    ) fsm_i (
        .clk(clk), .rst(rst),
        .cfg_pix_period(cfg_pix_period), .cfg_dummy_cnt(cfg_dummy_cnt),
        .cfg_integ_cyc(cfg_integ_cyc), .cfg_xfer_cyc(cfg_xfer_cyc),
        .cfg_mpp_en(cfg_mpp_en),
        .state(state), .cnt(cnt), .ph(ph), .pix(pix),
        .lat_half(lat_half), .lat_mpp(lat_mpp), .lat_rglow(lat_rglow)
    );

    lccd_out_decode #(
        .PIX_W(PIX_W), .INT_W(INT_W), .IDX_W(IDX_W),
        .N_LEAD(N_LEAD), .N_EFF(N_EFF), .ADC_OFF(ADC_OFF)
    ) dec_i (
        .clk(clk), .rst(rst),
        .state(state), .cnt(cnt), .ph(ph), .pix(pix),
        .lat_half(lat_half), .lat_mpp(lat_mpp), .lat_rglow(lat_rglow),
        .sh_close(sh_close), .xfer_gate(xfer_gate), .hclk1(hclk1), .hclk2(hclk2),
        .sum_gate(sum_gate), .rst_gate(rst_gate), .rgate_low(rgate_low),
        .pix_valid(pix_valid), .adc_strobe(adc_strobe), .line_start(line_start)
    );
endmodule

// File: tb/lccd_timing_gen_tb.sv
module lccd_timing_gen_tb_top;
    localparam int CLK_PER = 10;
    localparam int PIX_W = 8, N_W = 16, INT_W = 20;
    localparam int N_LEAD = 3, N_EFF = 8, N_TAIL = 2, TG_CYC = 6;
    localparam int MIN_INTEG = 5, MIN_PIX = 4, ADC_OFF = 1;
    localparam int N_TOT = N_LEAD + N_EFF + N_TAIL;

    // stimulus: pix, dummy, integ, xfer, mpp ; expected: line length, rgate_low cycles
    typedef struct packed {
        logic [7:0]  pix;
        logic [7:0]  dum;
        logic [15:0] integ;
        logic [15:0] xfer;
        logic        mpp;
        logic [15:0] exp_len;
        logic [15:0] exp_rgl;
    } vec_t;
    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'd4, 8'd0, 16'd10, 16'd3, 1'b0, 16'd68,  16'd0},
        '{8'd5, 8'd2, 16'd8,  16'd3, 1'b1, 16'd89,  16'd5},
        '{8'd2, 8'd1, 16'd3,  16'd0, 1'b1, 16'd67,  16'd5},
        '{8'd6, 8'd3, 16'd7,  16'd9, 1'b1, 16'd109, 16'd0},
        '{8'd7, 8'd0, 16'd20, 16'd4, 1'b0, 16'd117, 16'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PIX_W-1:0] cfg_pix_period = 8'd4;
    logic [N_W-1:0]   cfg_dummy_cnt = '0;
    logic [INT_W-1:0] cfg_integ_cyc = 20'd10;
    logic [INT_W-1:0] cfg_xfer_cyc = '0;
    logic             cfg_mpp_en = 1'b0;
    logic sh_close, xfer_gate, hclk1, hclk2, sum_gate, rst_gate;
    logic rgate_low, pix_valid, adc_strobe, line_start;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    lccd_timing_gen #(
        .PIX_W(PIX_W), .N_W(N_W), .INT_W(INT_W), .N_LEAD(N_LEAD), .N_EFF(N_EFF),
        .N_TAIL(N_TAIL), .TG_CYC(TG_CYC), .MIN_INTEG(MIN_INTEG),
        .MIN_PIX(MIN_PIX), .ADC_OFF(ADC_OFF)
    ) dut_i (
        .clk(clk), .rst(rst), .cfg_pix_period(cfg_pix_period),
        .cfg_dummy_cnt(cfg_dummy_cnt), .cfg_integ_cyc(cfg_integ_cyc),
        .cfg_xfer_cyc(cfg_xfer_cyc), .cfg_mpp_en(cfg_mpp_en),
        .sh_close(sh_close), .xfer_gate(xfer_gate), .hclk1(hclk1), .hclk2(hclk2),
        .sum_gate(sum_gate), .rst_gate(rst_gate), .rgate_low(rgate_low),
        .pix_valid(pix_valid), .adc_strobe(adc_strobe), .line_start(line_start)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cfg_pix_period = v.pix;
        cfg_dummy_cnt  = N_W'(v.dum);
        cfg_integ_cyc  = INT_W'(v.integ);
        cfg_xfer_cyc   = INT_W'(v.xfer);
        cfg_mpp_en     = v.mpp;
    endtask

    task automatic wait_start();
        int guard = 0;
        @(negedge clk);
        while (!line_start && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Measures one line from a visible line_start to the next; optional mid-line config change.
    task automatic measure(input vec_t v, input bit chg, input vec_t nv, input string tag);
        int len = 0, rg = 0, adc = 0, val = 0, h2 = 0, open = 0, rgl = 0, tg = 0;
        int rg_pre = 0, ls = 0, sg_bad = 0, tg_bad = 0;
        bit seen_valid = 0;
        int p = (v.pix < MIN_PIX) ? MIN_PIX : int'(v.pix);
        int i = (v.integ < MIN_INTEG) ? MIN_INTEG : int'(v.integ);
        int npix = N_TOT + int'(v.dum);
        wait_start();
        do begin
            len++;
            if (rst_gate) rg++;
            if (adc_strobe) adc++;
            if (pix_valid) begin val++; seen_valid = 1; end
            if (rst_gate && !pix_valid && !seen_valid) rg_pre++;
            if (hclk2) h2++;
            if (!sh_close) open++;
            if (rgate_low) rgl++;
            if (xfer_gate) tg++;
            if (line_start) ls++;
            if (sum_gate != hclk2) sg_bad++;
            if (xfer_gate && (!hclk1 || hclk2)) tg_bad++;
            if (chg && len == 20) apply(nv);
            @(negedge clk);
        end while (!line_start && len < 2000);
        check("R1", {tag, " line length"}, len, int'(v.exp_len));
        check("R1", {tag, " line_start pulses"}, ls, 1);
        check("R2", {tag, " xfer_gate cycles"}, tg, TG_CYC);
        check("R2", {tag, " hclk1 during xfer"}, tg_bad, 0);
        check("R3", {tag, " hclk2 high cycles"}, h2, npix * (p - p / 2));
        check("R3", {tag, " sum_gate vs hclk2"}, sg_bad, 0);
        check("R4", {tag, " rst_gate pulses"}, rg, npix);
        check("R4", {tag, " adc strobes"}, adc, npix);
        check("R5", {tag, " pix_valid cycles"}, val, N_EFF * p);
        check("R5", {tag, " pulses before valid"}, rg_pre, N_LEAD);
        check("R6", {tag, " shutter open cycles"}, open, i);
        check("R7", {tag, " rgate_low cycles"}, rgl, int'(v.exp_rgl));
    endtask

    task automatic check_idle(input string what);
        check("R9", {what, " sh_close"}, int'(sh_close), 1);
        check("R9", {what, " other outputs"},
              int'({xfer_gate, hclk1, hclk2, sum_gate, rst_gate, rgate_low,
                    pix_valid, adc_strobe, line_start}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("during reset");
        rst = 1'b0;
        @(negedge clk);
        check("R9", "line_start one clock after release", int'(line_start), 1);

        // table walk; the line after each apply carries that vector (R8)
        for (int k = 0; k < NV; k++) begin
            vec_t none = '0;
            apply(VECS[k]);
            measure(VECS[k], 1'b0, none, $sformatf("vec%0d", k));
        end

        // R8: mid-line change is deferred to the following line
        begin
            vec_t none = '0;
            apply(VECS[0]);
            wait_start();
            measure(VECS[0], 1'b1, VECS[4], "R8 old cfg kept");
            measure(VECS[4], 1'b0, none, "R8 new cfg next line");
        end

        // R9: reset in the middle of a readout
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("mid-line reset");
        rst = 1'b0;
        @(negedge clk);
        check("R9", "restart after mid-line reset", int'(line_start), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule